// File: doc/BRIEF.md
# Sequential Go/Done Group Controller

This block steps through a fixed list of sub-tasks, called groups, one at a time. Each group has its own go/done handshake and may take any number of cycles. A binary state register holds the index of the active group. While the top-level start input is high, the controller drives go to the active group until that group reports done, then moves the state on to the next index. Groups run in ascending index order.

When the state reaches the terminal value, one past the last group index, the controller raises its overall completion output for one cycle. On the same edge it writes the state back to zero, so it can run again at once. A group's done input can be qualified by a guard input. The parameter `GUARD_MASK` selects which groups use their guard. For groups without a guard, the raw done is used and the guard pin is ignored.

The state width is the ceiling of log2 of (group count + 1), with a minimum of one bit. All pins are plain control levels. No data passes through the block, so it has no valid/ready interface.

Top module: `seq_group_ctrl`

## Requirements
- R1: Reset is synchronous and active high and puts the state at zero. With `run` high after reset, bit 0 of `grp_go` is the first go raised.
- R2: `grp_go[i]` is high only when `run` is high, the state equals i, and group i's effective done is low.
- R3: When `run` is high, the state equals i, and group i's effective done is high, the state becomes i+1 at the next clock edge. `grp_go[i]` is low in that cycle.
- R4: For a group whose `GUARD_MASK` bit is 1, effective done is `grp_done[i] & grp_guard[i]`. For a group whose bit is 0, effective done is `grp_done[i]` alone and `grp_guard[i]` has no effect. The default mask is 4'b0101, so groups 0 and 2 are guarded.
- R5: Groups receive go strictly in index order 0, 1, …, N-1. A group's go stays high, cycle after cycle, until its effective done arrives.
- R6: `all_done` is high for exactly one cycle: the cycle after the last group's effective done. No `grp_go` bit is high in that cycle.
- R7: From the terminal state, the state returns to zero at the next edge whatever `run` is. If `run` is still high, group 0 receives go in the cycle right after `all_done`.
- R8: While `run` is low, every `grp_go` bit is low and a non-terminal state holds its value, even if the active group's done is high.
- R9: A done input from a group that is not active has no effect on the state or on any go.
- R10: At most one `grp_go` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Top-level go; the controller advances only while it is high |
| grp_done | input | N_GROUPS | Done source from each group |
| grp_guard | input | N_GROUPS | Qualifier for each group's done (used where GUARD_MASK bit is 1) |
| grp_go | output | N_GROUPS | Go to each group |
| all_done | output | 1 | One-cycle completion pulse |

## Verification
Full runs use a random done latency of zero to three cycles per group. These confirm the go ordering and that `all_done` lands exactly one cycle after the last done. Two runs back to back show the restart without an idle cycle. A done that is already high when a group becomes active shows that the go can be skipped entirely. Separate directed patterns tell apart:
- a guarded group from an unguarded one, by holding the guard low while done is high;
- a done from an inactive group against one from the active group;
- a done raised while `run` is low, which must not move the state.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  // Width of a binary state register that must encode n_states values.
  function automatic int state_bits(input int n_states);
    int b;
    b = $clog2(n_states);
    return (b > 1) ? b : 1;
  endfunction
endpackage

// File: rtl/seqc_done_qual.sv
module seqc_done_qual #(
  parameter int              N_GROUPS   = 4,
  parameter logic [N_GROUPS-1:0] GUARD_MASK = '0
) (
  input  logic [N_GROUPS-1:0] done_src,
  input  logic [N_GROUPS-1:0] guard,
  output logic [N_GROUPS-1:0] done_eff
);
  for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_qual
    if (GUARD_MASK[gi]) begin : g_guarded
      assign done_eff[gi] = done_src[gi] & guard[gi];
    end else begin : g_plain
      logic unused_guard;
      assign unused_guard   = guard[gi];
      assign done_eff[gi]   = done_src[gi];
    end
  end
endmodule

// File: rtl/seqc_step_decode.sv
module seqc_step_decode #(
  parameter int N_GROUPS = 4,
  parameter int STATE_W  = 3
) (
  input  logic [STATE_W-1:0]  state_q,
  input  logic                run,
  input  logic [N_GROUPS-1:0] done_eff,
  output logic [N_GROUPS-1:0] grp_go,
  output logic                wr_en,
  output logic [STATE_W-1:0]  wr_data,
  output logic                at_terminal
);
  localparam logic [STATE_W-1:0] TERM = STATE_W'(N_GROUPS);

  always_comb begin
    grp_go      = '0;
    wr_en       = 1'b0;
    wr_data     = '0;
    at_terminal = (state_q == TERM);
    for (int i = 0; i < N_GROUPS; i++) begin
      if (run && (state_q == STATE_W'(i))) begin
        if (done_eff[i]) begin
          wr_en   = 1'b1;
          wr_data = STATE_W'(i + 1);
        end else begin
          grp_go[i] = 1'b1;
        end
      end
    end
    // Terminal state rewinds unconditionally.
    if (at_terminal) begin
      wr_en   = 1'b1;
      wr_data = '0;
    end
  end
endmodule

// File: rtl/seqc_state_reg.sv
module seqc_state_reg #(
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_data,
  output logic [STATE_W-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (rst)        state_q <= '0;
    else if (wr_en) state_q <= wr_data;
  end
endmodule

// File: rtl/seq_group_ctrl.sv
module seq_group_ctrl #(
  parameter int                  N_GROUPS   = 4,
  parameter logic [N_GROUPS-1:0] GUARD_MASK = 4'b0101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [N_GROUPS-1:0] grp_done,
  input  logic [N_GROUPS-1:0] grp_guard,
  output logic [N_GROUPS-1:0] grp_go,
  output logic                all_done
);
  localparam int N_STATES = N_GROUPS + 1;
  localparam int STATE_W  = seqc_pkg::state_bits(N_STATES);

  logic [N_GROUPS-1:0] done_eff;
  logic [STATE_W-1:0]  state_q;
  logic [STATE_W-1:0]  wr_data;
  logic                wr_en;

  seqc_done_qual #(.N_GROUPS(N_GROUPS), .GUARD_MASK(GUARD_MASK)) u_qual (
    .done_src (grp_done),
    .guard    (grp_guard),
    .done_eff (done_eff)
  );

  seqc_step_decode #(.N_GROUPS(N_GROUPS), .STATE_W(STATE_W)) u_dec (
    .state_q     (state_q),
    .run         (run),
    .done_eff    (done_eff),
    .grp_go      (grp_go),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .at_terminal (all_done)
  );

  seqc_state_reg #(.STATE_W(STATE_W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .state_q (state_q)
  );
endmodule

// File: rtl/seqc_checker.sv
module seqc_checker #(
  parameter int N_GROUPS = 4,
  parameter int STATE_W  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                run,
  input logic [N_GROUPS-1:0] grp_go,
  input logic                all_done,
  input logic [STATE_W-1:0]  state_q
);
  localparam logic [STATE_W-1:0] TERM = STATE_W'(N_GROUPS);

  a_r10_go_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_go));

  a_r8_no_go_idle: assert property (@(posedge clk) disable iff (rst)
    !run |-> (grp_go == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && state_q != TERM) |=> $stable(state_q));

  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    all_done |=> !all_done);

  a_r6_no_go_at_end: assert property (@(posedge clk) disable iff (rst)
    all_done |-> (grp_go == '0));

  a_r7_rewind: assert property (@(posedge clk) disable iff (rst)
    all_done |=> (state_q == '0));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (state_q != TERM) |=> ((state_q == $past(state_q)) ||
                           (state_q == $past(state_q) + STATE_W'(1))));

  a_r2_go_matches_state: assert property (@(posedge clk) disable iff (rst)
    (grp_go != '0) |-> (grp_go[state_q] == 1'b1));
endmodule

bind seq_group_ctrl seqc_checker #(.N_GROUPS(N_GROUPS), .STATE_W(STATE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .grp_go   (grp_go),
  .all_done (all_done),
  .state_q  (state_q)
);

// File: tb/seq_group_ctrl_bench.sv
module seq_group_ctrl_bench;
  localparam int N = 4;
  localparam logic [N-1:0] GMASK = 4'b0101;

  logic         clk = 1'b0;
  logic         rst;
  logic         run;
  logic [N-1:0] grp_done;
  logic [N-1:0] grp_guard;
  logic [N-1:0] grp_go;
  logic         all_done;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  seq_group_ctrl #(.N_GROUPS(N), .GUARD_MASK(GMASK)) u_seq_group_ctrl (
    .clk(clk), .rst(rst), .run(run), .grp_done(grp_done),
    .grp_guard(grp_guard), .grp_go(grp_go), .all_done(all_done)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Lands one time unit after a rising edge (drive point).
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; grp_done = '0; grp_guard = '0;
    step(); step();
    rst = 1'b0;
  endtask

  // Starts with state 0 and run high; ends after the restart cycle.
  task automatic run_groups();
    for (int g = 0; g < N; g++) begin
      int lat = $urandom_range(0, 3);
      for (int k = 0; k < lat; k++) begin
        #1 chk(grp_go == N'(1 << g), "R5 order/hold", grp_go, 1 << g);
        step();
      end
      grp_done[g] = 1'b1; grp_guard[g] = 1'b1;
      #1 chk(grp_go == '0, "R3 go low on done", grp_go, 0);
      chk(all_done == 1'b0, "R6 no early done", all_done, 0);
      step();
      grp_done[g] = 1'b0; grp_guard[g] = 1'b0;
    end
    #1 chk(all_done == 1'b1, "R6 done after last", all_done, 1);
    chk(grp_go == '0, "R6 no go at end", grp_go, 0);
    step();
    #1 chk(all_done == 1'b0, "R6 single pulse", all_done, 0);
    chk(grp_go == 4'b0001, "R7 restart group0", grp_go, 1);
    step();
  endtask

  task automatic t_reset();
    do_reset();
    #1 chk(grp_go == '0, "R8 no go without run", grp_go, 0);
    chk(all_done == 1'b0, "R1 reset done low", all_done, 0);
    step();
    run = 1'b1;
    #1 chk(grp_go == 4'b0001, "R1 first go group0", grp_go, 1);
    step();
  endtask

  task automatic t_full_runs();
    do_reset(); run = 1'b1;
    run_groups();
    run_groups(); // back to back, R7
  endtask

  task automatic t_guard();
    do_reset(); run = 1'b1;
    grp_done[0] = 1'b1; grp_guard[0] = 1'b0;
    #1 chk(grp_go == 4'b0001, "R4 guarded done masked", grp_go, 1);
    step();
    #1 chk(grp_go == 4'b0001, "R4 no advance guard low", grp_go, 1);
    step();
    grp_guard[0] = 1'b1;
    #1 chk(grp_go == '0, "R4 guard high qualifies", grp_go, 0);
    step();
    grp_done[0] = 1'b0; grp_guard[0] = 1'b0;
    grp_done[1] = 1'b1; // unguarded, guard stays low
    #1 chk(grp_go == '0, "R4 unguarded ignores guard", grp_go, 0);
    step();
    grp_done[1] = 1'b0;
    #1 chk(grp_go == 4'b0100, "R4 advanced to group2", grp_go, 4);
    step();
  endtask

  task automatic t_inactive();
    do_reset(); run = 1'b1;
    grp_done[3:2] = 2'b11; grp_guard = '1;
    #1 chk(grp_go == 4'b0001, "R9 foreign done ignored", grp_go, 1);
    step();
    #1 chk(grp_go == 4'b0001, "R9 state unchanged", grp_go, 1);
    chk(all_done == 1'b0, "R9 no completion", all_done, 0);
    step();
    grp_done = '0; grp_guard = '0;
  endtask

  task automatic t_pause();
    do_reset(); run = 1'b1;
    grp_done[0] = 1'b1; grp_guard[0] = 1'b1;
    step();
    grp_done[0] = 1'b0; grp_guard[0] = 1'b0;
    #1 chk(grp_go == 4'b0010, "R3 moved to group1", grp_go, 2);
    step();
    run = 1'b0; grp_done[1] = 1'b1;
    #1 chk(grp_go == '0, "R8 go low when paused", grp_go, 0);
    step();
    step();
    grp_done[1] = 1'b0; run = 1'b1;
    #1 chk(grp_go == 4'b0010, "R8 state held in pause", grp_go, 2);
    step();
  endtask

  task automatic t_zero_latency();
    do_reset(); run = 1'b1;
    grp_done[1] = 1'b1; // ready before group1 becomes active
    grp_done[0] = 1'b1; grp_guard[0] = 1'b1;
    step();
    grp_done[0] = 1'b0; grp_guard[0] = 1'b0;
    #1 chk(grp_go == '0, "R2 go skipped when done early", grp_go, 0);
    step();
    grp_done[1] = 1'b0;
    #1 chk(grp_go == 4'b0100, "R5 next in order", grp_go, 4);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_full_runs();
    t_guard();
    t_inactive();
    t_pause();
    t_zero_latency();
    report();
  end
endmodule